// File: doc/BRIEF.md
# Three-Mode Bidirectional Bus Transceiver Channel Pair

This block moves a 20-bit word in each direction between an A-side and a B-side bus. Each direction has one storage element per bit. Two controls pick how that element behaves. A pass-through control makes the channel transparent. An active-low capture enable lets the channel take a new word on a rising edge of its own bus clock. With neither control active, the channel holds its word. A separate active-low drive control gives per-bit tri-state enables to the pad ring, which sits outside this block.

The whole block runs on one fast system clock. Each bus clock is sampled on that clock, and a rising edge is a low-to-high change seen between two successive samples. A chip-level test-mode input stops normal operation in both directions at once. It freezes the stored words and withdraws every output enable.

Each direction holds a small mode machine. The decoded modes are PASS, HOLD, CLOCKED and TEST, plus a RESET state left at the first system-clock edge after reset. Decode priority, highest first:
- TEST: test-mode input high.
- PASS: pass-through control high.
- CLOCKED: capture enable low.
- HOLD: all other cases.

Every mode can move to any other mode in the next cycle. Only two transitions change what is stored:
- PASS→HOLD and PASS→CLOCKED keep the last word passed.
- CLOCKED keeps capturing, but only when the sampled bus clock rises.

Top module: `ubt_transceiver`

## Requirements
- R1: Each direction carries 20 data bits. The B-to-A direction has exactly the same behaviour as A-to-B, using its own pass-through, capture-enable, bus-clock and drive controls.
- R2: While pass-through is high and test mode is low, the data output equals the data input in the same system-clock cycle. This is combinational, with no register delay.
- R3: When pass-through falls, the output keeps the input that was present in the last system-clock cycle in which pass-through was high.
- R4: With pass-through low and capture enable high, the stored word does not change, even while the bus clock toggles.
- R5: With pass-through low and the bus clock held at one level, the stored word does not change.
- R6: With pass-through low and capture enable low, a bus-clock level that is high in one system-clock cycle and was low in the cycle before stores the input of that cycle. The output shows the new word from the next cycle. A bus clock that is already high when reset is released does not count as a rising edge.
- R7: With the drive control low, all 20 output-enable bits are 1. With it high, all 20 bits are 0. The enables never take a mixed value.
- R8: While test mode is high, both directions drive all output enables to 0, ignore pass-through and bus-clock edges, keep their stored words, and present those stored words on their data outputs.
- R9: While reset is low, both stored words are zero and all output enables are 0. The enables stay 0 until the first system-clock edge after reset is released.
- R10: Each direction's controls have no effect on the other direction's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all controls |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Inhibits normal operation in both directions |
| a_in | input | 20 | A-side data toward B |
| ab_pass | input | 1 | A-to-B pass-through (transparent when high) |
| ab_cap_n | input | 1 | A-to-B active-low capture enable |
| ab_bus_clk | input | 1 | A-to-B bus clock, sampled on clk |
| ab_drive_n | input | 1 | A-to-B active-low drive control |
| b_out | output | 20 | Data toward B-side pads |
| b_oe | output | 20 | Per-bit output enable for B-side pads |
| b_in | input | 20 | B-side data toward A |
| ba_pass | input | 1 | B-to-A pass-through |
| ba_cap_n | input | 1 | B-to-A active-low capture enable |
| ba_bus_clk | input | 1 | B-to-A bus clock |
| ba_drive_n | input | 1 | B-to-A active-low drive control |
| a_out | output | 20 | Data toward A-side pads |
| a_oe | output | 20 | Per-bit output enable for A-side pads |

## Verification
The hardest case to reach is an edge capture that needs the bus clock to rise between two system-clock samples. That rise must come while pass-through is low, capture is enabled and test mode is off, and this combination is rare under uniform random controls.

The stimulus therefore weights pass-through low and toggles each bus clock at random on most cycles. Directed steps cover the rest:
- a bus clock held high across reset release;
- long static-clock stretches;
- pass-through falling with new data arriving in the same cycle;
- test mode raised while pass-through is high.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int unsigned UBT_WIDTH = 20;

    typedef enum logic [2:0] {
        MODE_RESET   = 3'd0,
        MODE_PASS    = 3'd1,
        MODE_HOLD    = 3'd2,
        MODE_CLOCKED = 3'd3,
        MODE_TEST    = 3'd4
    } ubt_mode_e;

endpackage

// File: rtl/ubt_clk_edge.sv
module ubt_clk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk,
    output logic rise
);

    logic prev_q;

    // Reset value 1: a bus clock already high at reset release is no edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= bus_clk;
        end
    end

    always_comb begin
        rise = bus_clk & ~prev_q;
    end

    // R6
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/ubt_mode_ctrl.sv
module ubt_mode_ctrl
    import ubt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      test_mode,
    input  logic      pass_en,
    input  logic      cap_n,
    input  logic      rise,
    output ubt_mode_e mode_now,
    output ubt_mode_e mode_q,
    output logic      live,
    output logic      show_input,
    output logic      load
);

    ubt_mode_e mode_d;

    always_comb begin
        if (test_mode) begin
            mode_d = MODE_TEST;
        end else if (pass_en) begin
            mode_d = MODE_PASS;
        end else if (!cap_n) begin
            mode_d = MODE_CLOCKED;
        end else begin
            mode_d = MODE_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        mode_now   = mode_d;
        live       = (mode_q != MODE_RESET);
        show_input = 1'b0;
        load       = 1'b0;
        unique case (mode_d)
            MODE_PASS: begin
                show_input = 1'b1;
                load       = 1'b1;
            end
            MODE_CLOCKED: begin
                load = rise;
            end
            MODE_HOLD, MODE_TEST, MODE_RESET: begin
                load = 1'b0;
            end
            default: begin
                load = 1'b0;
            end
        endcase
    end

    // R8
    test_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (!load && !show_input));

endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
    parameter int unsigned WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/ubt_channel.sv
module ubt_channel
    import ubt_pkg::*;
#(
    parameter int unsigned WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic [WIDTH-1:0] d_in,
    input  logic             pass_en,
    input  logic             cap_n,
    input  logic             bus_clk,
    input  logic             drive_n,
    output logic [WIDTH-1:0] d_out,
    output logic [WIDTH-1:0] d_oe
);

    logic             rise;
    logic             live;
    logic             show_input;
    logic             load;
    logic             drive;
    logic [WIDTH-1:0] store_q;
    ubt_mode_e        mode_now;
    ubt_mode_e        mode_q;

    ubt_clk_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_clk (bus_clk),
        .rise    (rise)
    );

    ubt_mode_ctrl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_mode  (test_mode),
        .pass_en    (pass_en),
        .cap_n      (cap_n),
        .rise       (rise),
        .mode_now   (mode_now),
        .mode_q     (mode_q),
        .live       (live),
        .show_input (show_input),
        .load       (load)
    );

    ubt_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (d_in),
        .q     (store_q)
    );

    always_comb begin
        drive = live && !drive_n && (mode_now != MODE_TEST);
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            d_out[i] = show_input ? d_in[i] : store_q[i];
            d_oe[i]  = drive;
        end
    end

    // R3
    pass_fall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pass_en) && $past(!test_mode) && !pass_en && !test_mode)
        |-> (d_out == $past(d_in)));

    // R4
    cap_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!pass_en && cap_n && !test_mode) && !pass_en && !test_mode)
        |-> (d_out == $past(d_out)));

    // R5
    static_clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!pass_en && !rise && !test_mode) && !pass_en && !test_mode)
        |-> (d_out == $past(d_out)));

    // R6
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rise && !pass_en && !cap_n && !test_mode) && !pass_en && !test_mode)
        |-> (d_out == $past(d_in)));

    // R7
    oe_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(d_oe) == 0) || ($countones(d_oe) == WIDTH));

    // R8
    test_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (d_oe == '0));

    // R8
    test_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(test_mode) && test_mode) |-> (d_out == $past(d_out)));

    // R9
    first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RESET) |-> (d_oe == '0));

endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver
    import ubt_pkg::*;
#(
    parameter int unsigned WIDTH = UBT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic [WIDTH-1:0] a_in,
    input  logic             ab_pass,
    input  logic             ab_cap_n,
    input  logic             ab_bus_clk,
    input  logic             ab_drive_n,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ba_pass,
    input  logic             ba_cap_n,
    input  logic             ba_bus_clk,
    input  logic             ba_drive_n,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe
);

    // R1: two identical channels, each with its own controls
    ubt_channel #(.WIDTH(WIDTH)) u_ab (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .d_in      (a_in),
        .pass_en   (ab_pass),
        .cap_n     (ab_cap_n),
        .bus_clk   (ab_bus_clk),
        .drive_n   (ab_drive_n),
        .d_out     (b_out),
        .d_oe      (b_oe)
    );

    ubt_channel #(.WIDTH(WIDTH)) u_ba (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .d_in      (b_in),
        .pass_en   (ba_pass),
        .cap_n     (ba_cap_n),
        .bus_clk   (ba_bus_clk),
        .drive_n   (ba_drive_n),
        .d_out     (a_out),
        .d_oe      (a_oe)
    );

    // R2
    ab_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_pass && !test_mode) |-> (b_out == a_in));

    // R2
    ba_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_pass && !test_mode) |-> (a_out == b_in));

endmodule

// File: tb/ubt_transceiver_bench.sv
`timescale 1ns/1ps
module ubt_transceiver_bench;

    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_mode = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_pass = 1'b0, ab_cap_n = 1'b1, ab_bus_clk = 1'b0, ab_drive_n = 1'b0;
    logic         ba_pass = 1'b0, ba_cap_n = 1'b1, ba_bus_clk = 1'b0, ba_drive_n = 1'b0;
    logic [W-1:0] b_out, b_oe, a_out, a_oe;

    int vectors = 0;
    int fails   = 0;

    // reference state per direction: 0 = A-to-B, 1 = B-to-A
    logic [W-1:0] m_store [2];
    logic         m_prev  [2];
    logic         m_live;

    always #2 clk = ~clk;

    ubt_transceiver #(.WIDTH(W)) u_ubt_transceiver (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .a_in(a_in), .ab_pass(ab_pass), .ab_cap_n(ab_cap_n),
        .ab_bus_clk(ab_bus_clk), .ab_drive_n(ab_drive_n),
        .b_out(b_out), .b_oe(b_oe),
        .b_in(b_in), .ba_pass(ba_pass), .ba_cap_n(ba_cap_n),
        .ba_bus_clk(ba_bus_clk), .ba_drive_n(ba_drive_n),
        .a_out(a_out), .a_oe(a_oe)
    );

    function automatic logic [W-1:0] exp_data(logic pass, logic tm, logic [W-1:0] d, logic [W-1:0] st);
        return (pass && !tm) ? d : st;
    endfunction

    function automatic logic [W-1:0] exp_oe(logic live, logic drv_n, logic tm);
        return (live && !drv_n && !tm) ? {W{1'b1}} : {W{1'b0}};
    endfunction

    function automatic string mode_tag(logic tm, logic pass, logic cap_n, logic bclk, logic prev);
        if (tm)               return "R8";
        if (pass)             return "R2";
        if (cap_n)            return "R4";
        if (bclk && !prev)    return "R6";
        return "R5";
    endfunction

    task automatic compare(string tag, string dir, logic [W-1:0] got_d, logic [W-1:0] want_d,
                           logic [W-1:0] got_oe, logic [W-1:0] want_oe);
        vectors++;
        if (got_d !== want_d || got_oe !== want_oe) begin
            fails++;
            $display("FAIL %s %s: data=%h expected=%h oe=%h expected=%h",
                     tag, dir, got_d, want_d, got_oe, want_oe);
        end
    endtask

    // Called just after a negedge with inputs set; checks, advances the model, waits for next negedge.
    task automatic step(string tag);
        string t0, t1;
        logic  r;
        #1;
        t0 = (tag != "") ? tag : mode_tag(test_mode, ab_pass, ab_cap_n, ab_bus_clk, m_prev[0]);
        t1 = (tag != "") ? tag : mode_tag(test_mode, ba_pass, ba_cap_n, ba_bus_clk, m_prev[1]);
        compare(t0, "A->B", b_out, exp_data(ab_pass, test_mode, a_in, m_store[0]),
                b_oe, exp_oe(m_live, ab_drive_n, test_mode));
        compare(t1, "B->A", a_out, exp_data(ba_pass, test_mode, b_in, m_store[1]),
                a_oe, exp_oe(m_live, ba_drive_n, test_mode));
        if (!rst_n) begin
            m_store[0] = '0; m_store[1] = '0;
            m_prev[0] = 1'b1; m_prev[1] = 1'b1;
            m_live = 1'b0;
        end else begin
            m_live = 1'b1;
            r = ab_bus_clk && !m_prev[0];
            if (!test_mode && (ab_pass || (!ab_cap_n && r))) m_store[0] = a_in;
            m_prev[0] = ab_bus_clk;
            r = ba_bus_clk && !m_prev[1];
            if (!test_mode && (ba_pass || (!ba_cap_n && r))) m_store[1] = b_in;
            m_prev[1] = ba_bus_clk;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        logic [W-1:0] held;
        seed_dummy = $urandom(32'h0B15_7A3C);
        m_store[0] = '0; m_store[1] = '0;
        m_prev[0] = 1'b1; m_prev[1] = 1'b1; m_live = 1'b0;
        @(negedge clk);

        // R9: in reset, stored zero and no drive
        a_in = 20'hABCDE; b_in = 20'h12345;
        step("R9");
        step("R9");
        // release with both bus clocks already high and capture enabled
        ab_bus_clk = 1'b1; ba_bus_clk = 1'b1; ab_cap_n = 1'b0; ba_cap_n = 1'b0;
        rst_n = 1'b1;
        step("R9");
        step("R6");  // high clock at release is no edge: stays zero
        step("R6");

        // R2: transparent, several patterns
        ab_pass = 1'b1; ba_pass = 1'b1;
        a_in = 20'hFFFFF; b_in = 20'h00000; step("R2");
        a_in = 20'hA5A5A; b_in = 20'h5A5A5; step("R2");
        a_in = 20'h00001; b_in = 20'h80000; step("R2");

        // R3: pass falls while new data arrives
        a_in = 20'h13579; b_in = 20'h2468A; step("R3");
        ab_pass = 1'b0; ba_pass = 1'b0; ab_cap_n = 1'b1; ba_cap_n = 1'b1;
        a_in = 20'h0F0F0; b_in = 20'hF0F0F; step("R3");

        // R4: capture disabled, clock toggling
        for (int i = 0; i < 6; i++) begin
            ab_bus_clk = ~ab_bus_clk; ba_bus_clk = ~ba_bus_clk;
            a_in = W'($urandom); b_in = W'($urandom);
            step("R4");
        end

        // R5: capture enabled, clock static low then static high
        ab_cap_n = 1'b0; ba_cap_n = 1'b0;
        ab_bus_clk = 1'b0; ba_bus_clk = 1'b0;
        a_in = 20'h11111; b_in = 20'h22222; step("R6");  // falling edge is no capture
        for (int i = 0; i < 4; i++) begin
            a_in = W'($urandom); b_in = W'($urandom); step("R5");
        end

        // R6: rising edge captures
        ab_bus_clk = 1'b1; ba_bus_clk = 1'b1;
        a_in = 20'hC0FFE; b_in = 20'hBEEF0; step("R6");
        a_in = 20'h00000; b_in = 20'hFFFFF; step("R5");  // held high: no new capture

        // R7: drive control
        ab_drive_n = 1'b1; ba_drive_n = 1'b0; step("R7");
        ab_drive_n = 1'b0; ba_drive_n = 1'b1; step("R7");
        ab_drive_n = 1'b0; ba_drive_n = 1'b0;

        // R8: test mode ignores pass-through and edges
        test_mode = 1'b1; ab_pass = 1'b1; ab_bus_clk = 1'b0; ba_bus_clk = 1'b0;
        a_in = 20'h77777; b_in = 20'h88888; step("R8");
        ab_bus_clk = 1'b1; ba_bus_clk = 1'b1; step("R8");
        test_mode = 1'b0; ab_pass = 1'b0; step("R8");

        // R10: A-to-B transparent while B-to-A holds
        ab_pass = 1'b1; ba_cap_n = 1'b1;
        held = 20'h3C3C3;
        for (int i = 0; i < 3; i++) begin
            a_in = held ^ W'(i); ba_bus_clk = ~ba_bus_clk; b_in = W'($urandom);
            step("R10");
        end

        // R1: random traffic in both directions
        for (int i = 0; i < 3000; i++) begin
            a_in = W'($urandom); b_in = W'($urandom);
            ab_pass = ($urandom_range(3) == 0);
            ba_pass = ($urandom_range(3) == 0);
            ab_cap_n = $urandom_range(1) == 1;
            ba_cap_n = $urandom_range(1) == 1;
            if ($urandom_range(2) != 0) ab_bus_clk = ~ab_bus_clk;
            if ($urandom_range(2) != 0) ba_bus_clk = ~ba_bus_clk;
            ab_drive_n = ($urandom_range(3) == 0);
            ba_drive_n = ($urandom_range(3) == 0);
            test_mode  = ($urandom_range(15) == 0);
            step("");
        end
        step("R1");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule